// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a logical address into a linear address. A logical address is a segment slot index plus an effective address. The unit holds six segment slots: CS, SS, DS, ES, FS and GS, indexed 0 to 5 in that order. Each slot has a visible 16-bit selector and a hidden copy of the descriptor data. That data is the base, the limit, a code/data flag, a read/write permission bit and a descriptor privilege level. Software fills a slot by presenting the selector and its descriptor data on a load port for one cycle. Later translations use only this cached copy.

Each valid request names a slot, an effective address, an access size, an access kind and the current privilege level. One cycle later the unit reports the linear address, or it reports a fault with a cause. The unit runs limit, type and privilege checks. A mode input chooses between legacy 32-bit behaviour (protected or compatibility) and 64-bit behaviour. In 64-bit behaviour, segmentation is almost transparent: only FS and GS add their base, and no limit check is made.

Top module: `seg_xlate`

## Requirements
- R1: After reset, out_valid and out_fault are 0, out_cause is 0 (none), and every slot holds selector 0, base 0, limit 0, a read-only data type and privilege level 0.
- R2: In 32-bit mode (mode64 = 0), a passing request gives out_lin = (slot base[31:0] + ea[31:0]) mod 2^32, zero-extended to 64 bits. The result appears on the clock edge after the request. The upper 32 bits of ea are ignored.
- R3: In 64-bit mode (mode64 = 1), a passing request gives out_lin = ea for CS, SS, DS and ES (indices 0 to 3). For FS and GS (indices 4 and 5) it gives the full 64-bit sum base + ea, modulo 2^64.
- R4: In 32-bit mode, a limit fault (cause 1) is raised when the last byte ea[31:0] + 2^size − 1 is above the slot limit. This sum is computed without wrapping. size codes 0 to 3 mean 1, 2, 4 and 8 bytes. In 64-bit mode no limit fault is ever raised.
- R5: A type fault (cause 2) is raised in the following cases. A fetch (kind 2) is made to a data slot (code flag 0). A write (kind 1) is made to a code slot, or to a data slot whose rw bit is 0. A read (kind 0) is made to a code slot whose rw bit is 0. The reserved kind 3 is used.
- R6: A privilege fault (cause 3) is raised when max(cpl, selector[1:0]) is greater than the slot's descriptor privilege level.
- R7: When several checks fail, the reported cause follows the order limit, then type, then privilege. A faulting request sets out_fault and clears out_valid. A passing request sets out_valid, clears out_fault and reports cause 0.
- R8: A load writes the selector and descriptor data into the slot named by ld_idx. A request to the same slot in the same cycle is translated with the values held before the load.
- R9: A request with slot index 6 or 7 gets a type fault. A load with index 6 or 7 changes no slot.
- R10: In the cycle after a cycle with req_valid low, out_valid and out_fault are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 selects 64-bit behaviour, 0 selects 32-bit behaviour |
| ld_en | input | 1 | Load a segment slot this cycle |
| ld_idx | input | 3 | Slot to load (0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS) |
| ld_sel | input | 16 | Selector value; bits [1:0] are the requested privilege level |
| ld_base | input | 64 | Segment base |
| ld_limit | input | 32 | Segment limit (offset of the last valid byte) |
| ld_code | input | 1 | 1 = code segment, 0 = data segment |
| ld_rw | input | 1 | Code: readable; data: writable |
| ld_dpl | input | 2 | Descriptor privilege level |
| req_valid | input | 1 | Translation request present |
| req_idx | input | 3 | Slot used by the request |
| req_ea | input | 64 | Effective address |
| req_size | input | 2 | Access size code (bytes = 2^size) |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Registered: request translated without fault |
| out_fault | output | 1 | Registered: request faulted |
| out_cause | output | 2 | Registered cause: 0 none, 1 limit, 2 type, 3 privilege |
| out_lin | output | 64 | Registered linear address |

## Verification
The six slots are loaded with contrasting descriptors: code and data, read-only and writable, small and full limits, privilege levels 0 and 3, and bases that wrap past 4 GiB. A table of requests then runs across both modes.

Base-plus-offset cases in 32-bit mode separate correct mod-2^32 wrapping from a wide sum, and they show that the upper effective-address bits are ignored. In 64-bit mode, the same kind of request on SS/CS and on FS/GS shows which slots add their base. Requests that end exactly on the limit, one byte past it, or past 4 GiB pin down the boundary of the limit check. Requests that fail two checks at once expose the cause priority.

Directed cases cover the reset state, idle cycles, a load and a request to the same slot in the same cycle, and loads or requests with the unused indices 6 and 7.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int unsigned ADDR_W  = 64;
    localparam int unsigned LEG_W   = 32;
    localparam int unsigned LIM_W   = 32;
    localparam int unsigned SEL_W   = 16;
    localparam int unsigned NUM_SEG = 6;
    localparam int unsigned IDX_W   = 3;
    localparam int unsigned PL_W    = 2;

    typedef enum logic [IDX_W-1:0] {
        SEG_CS = 3'd0,
        SEG_SS = 3'd1,
        SEG_DS = 3'd2,
        SEG_ES = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_idx_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LIMIT = 2'd1,
        CAUSE_TYPE  = 2'd2,
        CAUSE_PRIV  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              is_code;
        logic              rw;
        logic [PL_W-1:0]   dpl;
    } seg_ent_t;

    typedef struct packed {
        logic              valid;
        logic              fault;
        cause_e            cause;
        logic [ADDR_W-1:0] lin;
    } xl_res_t;

    function automatic logic [LEG_W:0] last_byte(input logic [LEG_W-1:0] off,
                                                 input logic [1:0] size);
        logic [LEG_W:0] span;
        span = ({{LEG_W{1'b0}}, 1'b1} << size) - 1'b1;
        return {1'b0, off} + span;
    endfunction

    function automatic logic access_type_ok(input seg_ent_t ent, input acc_e kind);
        case (kind)
            ACC_READ:  return !ent.is_code || ent.rw;
            ACC_WRITE: return !ent.is_code && ent.rw;
            ACC_FETCH: return ent.is_code;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic priv_ok(input logic [PL_W-1:0] cpl,
                                     input logic [PL_W-1:0] rpl,
                                     input logic [PL_W-1:0] dpl);
        logic [PL_W-1:0] eff;
        eff = (cpl > rpl) ? cpl : rpl;
        return eff <= dpl;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_pkg::*;
#(
    parameter int unsigned NSEG = NUM_SEG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  seg_ent_t         ld_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_ent_t         rd_ent,
    output logic             rd_hit
);

    seg_ent_t slot [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (ld_en && ld_idx == MY_IDX) begin
                slot[g] <= ld_ent;
            end
        end
    end

    always_comb begin
        rd_ent = '0;
        rd_hit = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_ent = slot[i];
                rd_hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
(
    input  logic              mode64,
    input  logic [IDX_W-1:0]  idx,
    input  logic              hit,
    input  seg_ent_t          ent,
    input  logic [ADDR_W-1:0] ea,
    input  logic [1:0]        size,
    input  acc_e              kind,
    input  logic [PL_W-1:0]   cpl,
    output cause_e            cause,
    output logic [ADDR_W-1:0] lin
);

    logic [LEG_W:0]    last;
    logic              lim_bad;
    logic              typ_bad;
    logic              prv_bad;
    logic              adds_base64;
    logic [LEG_W-1:0]  lin32;

    always_comb begin
        last    = last_byte(ea[LEG_W-1:0], size);
        lim_bad = hit && !mode64 && (last > {1'b0, ent.limit});
        typ_bad = !hit || !access_type_ok(ent, kind);
        prv_bad = !priv_ok(cpl, ent.sel[PL_W-1:0], ent.dpl);
    end

    // Fixed priority: limit over type over privilege.
    always_comb begin
        if (lim_bad)      cause = CAUSE_LIMIT;
        else if (typ_bad) cause = CAUSE_TYPE;
        else if (prv_bad) cause = CAUSE_PRIV;
        else              cause = CAUSE_NONE;
    end

    always_comb begin
        adds_base64 = (idx == SEG_FS) || (idx == SEG_GS);
        lin32       = ent.base[LEG_W-1:0] + ea[LEG_W-1:0];
        if (!mode64)          lin = {{(ADDR_W-LEG_W){1'b0}}, lin32};
        else if (adds_base64) lin = ent.base + ea;
        else                  lin = ea;
    end

    // R9: an unknown slot index can only end in a type fault.
    always_comb begin
        if (!hit) begin
            a_r9_bad_index_type: assert (cause == CAUSE_TYPE);
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int unsigned NSEG = NUM_SEG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode64,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    input  logic              ld_code,
    input  logic              ld_rw,
    input  logic [PL_W-1:0]   ld_dpl,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_kind,
    input  logic [PL_W-1:0]   req_cpl,
    output logic              out_valid,
    output logic              out_fault,
    output logic [1:0]        out_cause,
    output logic [ADDR_W-1:0] out_lin
);

    seg_ent_t          ld_ent;
    seg_ent_t          rd_ent;
    logic              rd_hit;
    cause_e            chk_cause;
    logic [ADDR_W-1:0] chk_lin;
    xl_res_t           res_q;

    always_comb begin
        ld_ent.sel     = ld_sel;
        ld_ent.base    = ld_base;
        ld_ent.limit   = ld_limit;
        ld_ent.is_code = ld_code;
        ld_ent.rw      = ld_rw;
        ld_ent.dpl     = ld_dpl;
    end

    seg_regfile #(.NSEG(NSEG)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_idx (ld_idx),
        .ld_ent (ld_ent),
        .rd_idx (req_idx),
        .rd_ent (rd_ent),
        .rd_hit (rd_hit)
    );

    seg_check u_chk (
        .mode64 (mode64),
        .idx    (req_idx),
        .hit    (rd_hit),
        .ent    (rd_ent),
        .ea     (req_ea),
        .size   (req_size),
        .kind   (acc_e'(req_kind)),
        .cpl    (req_cpl),
        .cause  (chk_cause),
        .lin    (chk_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= req_valid && (chk_cause == CAUSE_NONE);
            res_q.fault <= req_valid && (chk_cause != CAUSE_NONE);
            res_q.cause <= req_valid ? chk_cause : CAUSE_NONE;
            res_q.lin   <= chk_lin;
        end
    end

    assign out_valid = res_q.valid;
    assign out_fault = res_q.fault;
    assign out_cause = res_q.cause;
    assign out_lin   = res_q.lin;

    a_r7_valid_fault_excl: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_fault));

    a_r7_fault_has_cause: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> out_cause != CAUSE_NONE);

    a_r7_pass_no_cause: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_cause == CAUSE_NONE);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid && !out_fault);

    a_r7_request_answered: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid || out_fault);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        req_valid && !mode64 |=> out_lin[ADDR_W-1:LEG_W] == '0);

    a_r4_no_limit_64: assert property (@(posedge clk) disable iff (rst)
        req_valid && mode64 |=> out_cause != CAUSE_LIMIT);

    a_r3_flat_low_slots: assert property (@(posedge clk) disable iff (rst)
        req_valid && mode64 && req_idx < SEG_FS |=> out_lin == $past(req_ea));

endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode64;
    logic        ld_en;
    logic [2:0]  ld_idx;
    logic [15:0] ld_sel;
    logic [63:0] ld_base;
    logic [31:0] ld_limit;
    logic        ld_code;
    logic        ld_rw;
    logic [1:0]  ld_dpl;
    logic        req_valid;
    logic [2:0]  req_idx;
    logic [63:0] req_ea;
    logic [1:0]  req_size;
    logic [1:0]  req_kind;
    logic [1:0]  req_cpl;
    logic        out_valid;
    logic        out_fault;
    logic [1:0]  out_cause;
    logic [63:0] out_lin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    seg_xlate dut_i (
        .clk(clk), .rst(rst), .mode64(mode64),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_sel(ld_sel), .ld_base(ld_base),
        .ld_limit(ld_limit), .ld_code(ld_code), .ld_rw(ld_rw), .ld_dpl(ld_dpl),
        .req_valid(req_valid), .req_idx(req_idx), .req_ea(req_ea),
        .req_size(req_size), .req_kind(req_kind), .req_cpl(req_cpl),
        .out_valid(out_valid), .out_fault(out_fault), .out_cause(out_cause),
        .out_lin(out_lin)
    );

    typedef struct packed {
        logic        m;
        logic [2:0]  idx;
        logic [63:0] ea;
        logic [1:0]  sz;
        logic [1:0]  kind;
        logic [1:0]  cpl;
        logic [1:0]  cause;
        logic [63:0] lin;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 64'h10,                  2'd0, 2'd2, 2'd0, 2'd0, 64'h1010},
        '{1'b0, 3'd2, 64'h2000,                2'd2, 2'd0, 2'd0, 2'd0, 64'h1000},
        '{1'b0, 3'd1, 64'hFFC,                 2'd2, 2'd1, 2'd0, 2'd0, 64'h2000_0FFC},
        '{1'b0, 3'd1, 64'hFFD,                 2'd2, 2'd1, 2'd0, 2'd1, 64'h0},
        '{1'b0, 3'd3, 64'h0,                   2'd0, 2'd1, 2'd3, 2'd2, 64'h0},
        '{1'b0, 3'd3, 64'h10,                  2'd0, 2'd0, 2'd3, 2'd0, 64'h510},
        '{1'b0, 3'd1, 64'h0,                   2'd0, 2'd0, 2'd3, 2'd3, 64'h0},
        '{1'b0, 3'd3, 64'h100,                 2'd0, 2'd1, 2'd3, 2'd1, 64'h0},
        '{1'b0, 3'd5, 64'h0,                   2'd0, 2'd0, 2'd0, 2'd2, 64'h0},
        '{1'b0, 3'd0, 64'h0,                   2'd0, 2'd1, 2'd0, 2'd2, 64'h0},
        '{1'b1, 3'd0, 64'h0000_1234_5678_9ABC, 2'd0, 2'd2, 2'd0, 2'd0, 64'h0000_1234_5678_9ABC},
        '{1'b1, 3'd1, 64'h5000,                2'd3, 2'd0, 2'd0, 2'd0, 64'h5000},
        '{1'b1, 3'd4, 64'h1000,                2'd3, 2'd1, 2'd0, 2'd0, 64'h0000_7000_0000_1000},
        '{1'b1, 3'd5, 64'h0,                   2'd0, 2'd2, 2'd0, 2'd3, 64'h0},
        '{1'b0, 3'd2, 64'hFFFF_FFFE,           2'd2, 2'd0, 2'd0, 2'd1, 64'h0},
        '{1'b0, 3'd6, 64'h0,                   2'd0, 2'd0, 2'd0, 2'd2, 64'h0},
        '{1'b0, 3'd4, 64'hF,                   2'd0, 2'd0, 2'd0, 2'd0, 64'hF},
        '{1'b0, 3'd0, 64'hABCD_0000_0000_0010, 2'd0, 2'd2, 2'd0, 2'd0, 64'h1010},
        '{1'b0, 3'd2, 64'h0,                   2'd0, 2'd3, 2'd0, 2'd2, 64'h0},
        '{1'b0, 3'd2, 64'h0,                   2'd0, 2'd1, 2'd3, 2'd0, 64'hFFFF_F000}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [15:0] sel,
                        input logic [63:0] base, input logic [31:0] lim,
                        input logic code, input logic rw, input logic [1:0] dpl);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_sel = sel; ld_base = base;
        ld_limit = lim; ld_code = code; ld_rw = rw; ld_dpl = dpl;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Drives a request at a falling edge; outputs are sampled one falling edge later.
    task automatic request(input logic m, input logic [2:0] idx, input logic [63:0] ea,
                           input logic [1:0] sz, input logic [1:0] kind,
                           input logic [1:0] cpl);
        mode64 = m; req_valid = 1'b1; req_idx = idx; req_ea = ea;
        req_size = sz; req_kind = kind; req_cpl = cpl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [1:0] cause,
                              input logic [63:0] lin);
        check(out_cause == cause, req, 64'(out_cause), 64'(cause));
        check(out_valid == (cause == 2'd0), {req, " valid"}, 64'(out_valid),
              64'(cause == 2'd0));
        check(out_fault == (cause != 2'd0), {req, " fault"}, 64'(out_fault),
              64'(cause != 2'd0));
        if (cause == 2'd0) check(out_lin == lin, {req, " lin"}, out_lin, lin);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode64 = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_sel = '0;
        ld_base = '0; ld_limit = '0; ld_code = 1'b0; ld_rw = 1'b0; ld_dpl = '0;
        req_valid = 1'b0; req_idx = '0; req_ea = '0; req_size = '0;
        req_kind = '0; req_cpl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset outputs quiet
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(out_fault == 1'b0, "R1 out_fault", 64'(out_fault), 64'd0);
        check(out_cause == 2'd0, "R1 out_cause", 64'(out_cause), 64'd0);
        // R1: reset slot is a read-only data segment with limit 0 and base 0
        request(1'b0, 3'd2, 64'h0, 2'd0, 2'd0, 2'd0);
        expect_res("R1 reset slot read", 2'd0, 64'h0);
        request(1'b0, 3'd2, 64'h0, 2'd0, 2'd1, 2'd0);
        expect_res("R1 reset slot write", 2'd2, 64'h0);
        request(1'b0, 3'd2, 64'h1, 2'd0, 2'd0, 2'd0);
        expect_res("R1 reset slot limit", 2'd1, 64'h0);

        // R8: slot loads
        load(3'd0, 16'h0008, 64'h1000,                 32'h0000_FFFF, 1'b1, 1'b1, 2'd0);
        load(3'd1, 16'h0010, 64'h2000_0000,            32'h0000_0FFF, 1'b0, 1'b1, 2'd0);
        load(3'd2, 16'h0018, 64'hFFFF_F000,            32'hFFFF_FFFF, 1'b0, 1'b1, 2'd3);
        load(3'd3, 16'h0023, 64'h500,                  32'h0000_00FF, 1'b0, 1'b0, 2'd3);
        load(3'd4, 16'h0030, 64'h0000_7000_0000_0000,  32'h0000_0010, 1'b0, 1'b1, 2'd0);
        load(3'd5, 16'h003B, 64'h100,                  32'h0000_0007, 1'b1, 1'b0, 2'd0);

        // Vector table: covers R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            request(VECS[i].m, VECS[i].idx, VECS[i].ea, VECS[i].sz,
                    VECS[i].kind, VECS[i].cpl);
            expect_res($sformatf("R2-7 vec%0d (R2 R3 R4 R5 R6 R7)", i),
                       VECS[i].cause, VECS[i].lin);
        end

        // R10: idle cycle gives neither valid nor fault
        @(negedge clk);
        check(!out_valid && !out_fault, "R10 idle", 64'({out_valid, out_fault}), 64'd0);

        // R8: load and request to DS in the same cycle see the old base
        ld_en = 1'b1; ld_idx = 3'd2; ld_sel = 16'h0018; ld_base = 64'h4000;
        ld_limit = 32'hFFFF_FFFF; ld_code = 1'b0; ld_rw = 1'b1; ld_dpl = 2'd3;
        request(1'b0, 3'd2, 64'h0, 2'd0, 2'd0, 2'd0);
        ld_en = 1'b0;
        expect_res("R8 same-cycle old base", 2'd0, 64'hFFFF_F000);
        request(1'b0, 3'd2, 64'h0, 2'd0, 2'd0, 2'd0);
        expect_res("R8 new base used", 2'd0, 64'h4000);

        // R9: loads to index 7 and 6 change no slot
        load(3'd7, 16'h0000, 64'hDEAD_0000, 32'h0, 1'b1, 1'b0, 2'd0);
        load(3'd6, 16'h0000, 64'hBEEF_0000, 32'h0, 1'b1, 1'b0, 2'd0);
        for (int s = 0; s < 6; s++) begin
            request(1'b1, 3'(s), 64'h20, 2'd0, 2'd0, 2'd0);
            case (s)
                0: expect_res("R9 CS kept", 2'd0, 64'h20);
                1: expect_res("R9 SS kept", 2'd0, 64'h20);
                2: expect_res("R9 DS kept", 2'd0, 64'h20);
                3: expect_res("R9 ES kept", 2'd0, 64'h20);
                4: expect_res("R9 FS kept", 2'd0, 64'h0000_7000_0000_0020);
                default: expect_res("R9 GS kept", 2'd2, 64'h0);
            endcase
        end
        request(1'b0, 3'd7, 64'h0, 2'd0, 2'd0, 2'd0);
        expect_res("R9 index 7 request", 2'd2, 64'h0);
        request(1'b0, 3'd1, 64'h4, 2'd0, 2'd0, 2'd0);
        expect_res("R9 SS after bad loads", 2'd0, 64'h2000_0004);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule